// File: doc/BRIEF.md
# Receiver Status Interrupt Controller

This block collects eight status events from a digital audio receiver and reports them on two interrupt pins and a status byte. Some events are levels that the status byte follows directly (lock loss, compressed-stream detect, DTS-CD detect, non-audio flag, validity flag). Others mark something that happened once (parity error, channel-status change, Q-subcode update). These latch in the status byte until software reads it.

Each pin has its own mask, so software chooses which events drive it. When every unmasked source has gone away, a pin does not drop at once. It stays high for a hold time of 0, 512, 1024 or 4096 sample periods, counted on a one-cycle sample tick, and that hold time is selected by a 2-bit code. Software reads the status byte and then pulses the read strobe, which clears the latched bits. The masks and the hold code are steady inputs from the surrounding register file. Its reset values are provided as package constants.

Top module: `rx_event_irq`

## Requirements
- R1: Status bit positions: 0 lock loss, 1 parity error, 2 channel-status change, 3 Q-subcode update, 4 compressed stream, 5 DTS-CD stream, 6 non-audio, 7 validity. Bits 0, 4, 5, 6 and 7 follow `eventIn` one clock later.
- R2: Bits 1, 2 and 3 are set by a one-cycle event and stay at 1 until a `statusRd` pulse.
- R3: A `statusRd` pulse clears the latched bits on the next edge. If the same bit's event is high in that cycle, the bit stays 1.
- R4: A pin (`irq0` uses `mask0`, `irq1` uses `mask1`) rises one clock after a status bit whose mask bit is 0 becomes 1. An event whose mask bit is 1 never raises that pin, although it still appears in `status`.
- R5: The reset masks 8'hFC (pin 0) and 8'h8F (pin 1) route lock loss and parity error to `irq0`, and compressed stream, DTS-CD and non-audio to `irq1`.
- R6: Hold code 2'b00 gives no hold: the pin falls one clock after its last source bit clears. Codes 2'b01, 2'b10 and 2'b11 keep the pin high until 1024, 512 and 4096 `lrckTick` pulses have arrived after the source cleared.
- R7: The hold count restarts in full whenever an unmasked source becomes active again.
- R8: After reset, `status` is 0 and both pins are low.
- R9: The two pins time their holds independently. An event masked for one pin leaves that pin low while the other pin holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eventIn | input | 8 | Event levels and pulses, positions as in R1 |
| lrckTick | input | 1 | One-cycle pulse per sample period |
| statusRd | input | 1 | Status read strobe; clears latched bits |
| mask0 | input | 8 | Mask for irq0, 1 = event ignored |
| mask1 | input | 8 | Mask for irq1, 1 = event ignored |
| holdSel | input | 2 | Hold time code |
| irq0 | output | 1 | Interrupt pin 0, active high, registered |
| irq1 | output | 1 | Interrupt pin 1, active high, registered |
| status | output | 8 | Status byte |

## Verification
The bench fires an event in the same cycle as a read strobe. A design that lets the clear win would lose an event that arrived during the read. It counts sample ticks to within one of each hold limit, so an off-by-one counter, or a decode that swaps the 512 and 1024 codes, shows up as a pin falling one tick early or staying up too long. It reasserts a source halfway through a hold and checks the pin still holds past the original deadline, which exposes a counter that only reloads from idle. It also checks that a latched parity error keeps its pin up until the read, and that masked events never move a pin.

// File: rtl/rx_event_irq_pkg.sv
package rx_event_irq_pkg;
  localparam int EV_W  = 8;
  localparam int PIN_N = 2;

  localparam int EV_UNLOCK   = 0;
  localparam int EV_PARITY   = 1;
  localparam int EV_CSCHANGE = 2;
  localparam int EV_QSUB     = 3;
  localparam int EV_NONPCM   = 4;
  localparam int EV_DTSCD    = 5;
  localparam int EV_NONAUDIO = 6;
  localparam int EV_VALIDITY = 7;

  // bits that latch until a status read
  localparam logic [EV_W-1:0] STICKY_BITS =
    (EV_W'(1) << EV_PARITY) | (EV_W'(1) << EV_CSCHANGE) | (EV_W'(1) << EV_QSUB);

  // reset values of the two mask registers (1 = ignored)
  localparam logic [EV_W-1:0] DEF_MASK0 = 8'hFC;
  localparam logic [EV_W-1:0] DEF_MASK1 = 8'h8F;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSticky;
  } ctlStrobe_t;
endpackage

// File: rtl/rx_event_irq_hold.sv
module rx_event_irq_hold #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic             tick,
  input  logic [CNT_W-1:0] holdLen,
  output logic             pinQ
);
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ <= 1'b0;
      cntQ <= '0;
    end else if (active) begin
      // any live source restarts the full hold
      pinQ <= 1'b1;
      cntQ <= holdLen;
    end else if (pinQ) begin
      if (cntQ == '0) pinQ <= 1'b0;
      else if (tick)  cntQ <= cntQ - 1'b1;
    end
  end
endmodule

// File: rtl/rx_event_irq_datapath.sv
module rx_event_irq_datapath
  import rx_event_irq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [EV_W-1:0]            eventIn,
  input  ctlStrobe_t                 strobe,
  input  logic [PIN_N-1:0][EV_W-1:0] maskIn,
  output logic [EV_W-1:0]            statusQ,
  output logic [PIN_N-1:0]           srcActive
);
  logic [EV_W-1:0] keepBits;

  // latched bits survive unless a read clears them; live events always set
  assign keepBits = statusQ & STICKY_BITS & ~{EV_W{strobe.clrSticky}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= keepBits | eventIn;
  end

  for (genvar p = 0; p < PIN_N; p++) begin : g_src
    assign srcActive[p] = |(statusQ & ~maskIn[p]);
  end
endmodule

// File: rtl/rx_event_irq_control.sv
module rx_event_irq_control
  import rx_event_irq_pkg::*;
#(
  parameter int HOLD_SHORT = 512,
  parameter int HOLD_MID   = 1024,
  parameter int HOLD_LONG  = 4096,
  localparam int CNT_W     = $clog2(HOLD_LONG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             statusRd,
  input  logic             lrckTick,
  input  logic [1:0]       holdSel,
  input  logic [PIN_N-1:0] srcActive,
  output ctlStrobe_t       strobe,
  output logic [PIN_N-1:0] irqQ
);
  logic [CNT_W-1:0] holdLen;

  always_comb begin
    strobe.clrSticky = statusRd;
    unique case (holdSel)
      2'b00:   holdLen = '0;
      2'b01:   holdLen = CNT_W'(HOLD_MID);
      2'b10:   holdLen = CNT_W'(HOLD_SHORT);
      default: holdLen = CNT_W'(HOLD_LONG);
    endcase
  end

  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    rx_event_irq_hold #(.CNT_W(CNT_W)) u_hold (
      .clk    (clk),
      .rstN   (rstN),
      .active (srcActive[p]),
      .tick   (lrckTick),
      .holdLen(holdLen),
      .pinQ   (irqQ[p])
    );
  end
endmodule

// File: rtl/rx_event_irq.sv
module rx_event_irq
  import rx_event_irq_pkg::*;
#(
  parameter int HOLD_SHORT = 512,
  parameter int HOLD_MID   = 1024,
  parameter int HOLD_LONG  = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] eventIn,
  input  logic       lrckTick,
  input  logic       statusRd,
  input  logic [7:0] mask0,
  input  logic [7:0] mask1,
  input  logic [1:0] holdSel,
  output logic       irq0,
  output logic       irq1,
  output logic [7:0] status
);
  ctlStrobe_t                 strobe;
  logic [PIN_N-1:0]           srcActive;
  logic [PIN_N-1:0]           irqQ;
  logic [PIN_N-1:0][EV_W-1:0] maskIn;

  assign maskIn = {mask1, mask0};

  rx_event_irq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .eventIn  (eventIn),
    .strobe   (strobe),
    .maskIn   (maskIn),
    .statusQ  (status),
    .srcActive(srcActive)
  );

  rx_event_irq_control #(
    .HOLD_SHORT(HOLD_SHORT),
    .HOLD_MID  (HOLD_MID),
    .HOLD_LONG (HOLD_LONG)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .statusRd (statusRd),
    .lrckTick (lrckTick),
    .holdSel  (holdSel),
    .srcActive(srcActive),
    .strobe   (strobe),
    .irqQ     (irqQ)
  );

  assign irq0 = irqQ[0];
  assign irq1 = irqQ[1];
endmodule

// File: rtl/rx_event_irq_chk.sv
module rx_event_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] eventIn,
  input logic       statusRd,
  input logic [7:0] mask0,
  input logic [7:0] mask1,
  input logic       irq0,
  input logic       irq1,
  input logic [7:0] status
);
  a_r1_level_set: assert property (@(posedge clk) disable iff (!rstN)
    eventIn[0] |=> status[0]);
  a_r1_level_clear: assert property (@(posedge clk) disable iff (!rstN)
    !eventIn[7] |=> !status[7]);
  a_r2_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    (status[1] && !statusRd) |=> status[1]);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !eventIn[2]) |=> !status[2]);
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && eventIn[3]) |=> status[3]);
  a_r4_pin0_follows: assert property (@(posedge clk) disable iff (!rstN)
    (|(status & ~mask0)) |=> irq0);
  a_r4_pin0_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!irq0 && !(|(status & ~mask0))) |=> !irq0);
  a_r9_pin1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!irq1 && !(|(status & ~mask1))) |=> !irq1);
endmodule

bind rx_event_irq rx_event_irq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .eventIn (eventIn),
  .statusRd(statusRd),
  .mask0   (mask0),
  .mask1   (mask1),
  .irq0    (irq0),
  .irq1    (irq1),
  .status  (status)
);

// File: tb/rx_event_irq_tb.sv
module rx_event_irq_tb;
  import rx_event_irq_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] eventIn = '0;
  logic       lrckTick = 1'b0;
  logic       statusRd = 1'b0;
  logic [7:0] mask0 = DEF_MASK0;
  logic [7:0] mask1 = DEF_MASK1;
  logic [1:0] holdSel = 2'b00;
  logic       irq0, irq1;
  logic [7:0] status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_event_irq u_dut (
    .clk(clk), .rstN(rstN), .eventIn(eventIn), .lrckTick(lrckTick),
    .statusRd(statusRd), .mask0(mask0), .mask1(mask1), .holdSel(holdSel),
    .irq0(irq0), .irq1(irq1), .status(status)
  );

  // {event, mask0, mask1, expected irq0, expected irq1}
  localparam logic [25:0] VEC [7] = '{
    {8'h01, 8'hFC, 8'h8F, 2'b10},
    {8'h10, 8'hFC, 8'h8F, 2'b01},
    {8'h80, 8'hFC, 8'h8F, 2'b00},
    {8'hFF, 8'hFF, 8'hFF, 2'b00},
    {8'h80, 8'h7F, 8'hFF, 2'b10},
    {8'h04, 8'hFF, 8'hFB, 2'b01},
    {8'h60, 8'hFC, 8'h8F, 2'b01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      lrckTick = 1'b1;
      @(negedge clk);
      lrckTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic readStatus();
    statusRd = 1'b1;
    cyc(1);
    statusRd = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    cyc(3);
    chk("R8 status after reset", status, 8'h00);
    chk("R8 irq0 after reset", irq0, 1'b0);
    chk("R8 irq1 after reset", irq1, 1'b0);
    rstN = 1'b1;
    cyc(2);

    // table walk, zero hold
    for (int v = 0; v < 7; v++) begin
      mask0 = VEC[v][17:10];
      mask1 = VEC[v][9:2];
      eventIn = VEC[v][25:18];
      cyc(2);
      chk("R1/R2 status capture", status, VEC[v][25:18]);
      chk("R4 irq0 masking", irq0, VEC[v][1]);
      chk("R4 irq1 masking", irq1, VEC[v][0]);
      eventIn = '0;
      readStatus();
      cyc(3);
      chk("R3 status cleared", status, 8'h00);
      chk("R6 pins low with zero hold", {irq0, irq1}, 2'b00);
    end

    // default routing (R5)
    mask0 = DEF_MASK0;
    mask1 = DEF_MASK1;
    eventIn = 8'h20;
    cyc(2);
    chk("R5 dts routes to irq1", {irq0, irq1}, 2'b01);
    eventIn = 8'h02;
    cyc(2);
    chk("R5 parity routes to irq0 only", {irq0, irq1}, 2'b10);
    eventIn = '0;
    readStatus();
    cyc(3);

    // latched parity keeps pin up until read (R2)
    eventIn[EV_PARITY] = 1'b1;
    cyc(1);
    eventIn = '0;
    cyc(5);
    chk("R2 parity latched", status, 8'h02);
    chk("R2 latched bit holds irq0", irq0, 1'b1);
    readStatus();
    chk("R2 read clears parity", status, 8'h00);
    cyc(2);
    chk("R2 irq0 drops after read", irq0, 1'b0);

    // read in same cycle as event (R3)
    eventIn[EV_CSCHANGE] = 1'b1;
    cyc(1);
    statusRd = 1'b1;
    cyc(1);
    statusRd = 1'b0;
    chk("R3 event wins over clear", status[EV_CSCHANGE], 1'b1);
    eventIn = '0;
    readStatus();
    chk("R3 clear without event", status, 8'h00);

    // exact zero-hold timing (R6)
    eventIn = 8'h01;
    cyc(2);
    eventIn = '0;
    cyc(1);
    chk("R6 zero hold one edge after source", irq0, 1'b1);
    cyc(1);
    chk("R6 zero hold falls", irq0, 1'b0);

    // hold codes (R6, R9)
    for (int h = 1; h < 4; h++) begin
      int n;
      n = (h == 1) ? 1024 : (h == 2) ? 512 : 4096;
      holdSel = 2'(h);
      eventIn = 8'h01;
      cyc(2);
      eventIn = '0;
      cyc(2);
      ticks(n - 1);
      chk("R6 hold still high one tick short", irq0, 1'b1);
      chk("R9 irq1 untouched by irq0 hold", irq1, 1'b0);
      ticks(1);
      chk("R6 hold ends at limit", irq0, 1'b0);
    end

    // restart on reassert (R7)
    holdSel = 2'b01;
    eventIn = 8'h01;
    cyc(2);
    eventIn = '0;
    cyc(2);
    ticks(600);
    chk("R7 mid hold", irq0, 1'b1);
    eventIn = 8'h01;
    cyc(2);
    eventIn = '0;
    cyc(2);
    ticks(1000);
    chk("R7 restarted hold past first deadline", irq0, 1'b1);
    ticks(24);
    chk("R7 restarted hold ends", irq0, 1'b0);

    // pin 1 hold independent of pin 0 (R9)
    eventIn = 8'h10;
    cyc(2);
    eventIn = '0;
    cyc(2);
    ticks(10);
    chk("R9 irq1 holds alone", {irq0, irq1}, 2'b01);
    ticks(1014);
    chk("R9 irq1 hold ends", irq1, 1'b0);

    finishRun();
  end
endmodule